// File: doc/BRIEF.md
# Randomized Sequence Start Limiter

This block decides, on every clock, which of N stimulus sequences are allowed to begin. Each sequence has a set of limits. It may wait on a Boolean condition input. It may belong to one or more spacing groups, which enforce a minimum number of cycles between starts. It may belong to one or more occupancy groups, which cap how many instances of the member sequences can be live at once. Which limits apply to which sequence is fixed by parameters. Limits can be shared, so several sequences can be coupled through one spacing or occupancy group.

When every limit for a sequence passes, the sequence still starts only if it wins a random draw. The draw compares a slice of a seeded 32-bit linear-feedback shift register against a per-sequence probability code. A start is a single-cycle pulse on that sequence's bit of `start_o`. The block counts each sequence's live instances from the start pulse until the matching completion pulse on `done_i`. A sequencer that plays back the stimulus would sit behind this block, pulsing `done_i` in the final cycle of each instance.

`start_o` depends combinationally on the current cycle's `cond_i` and `prob_i`. All internal state changes on the rising clock edge.

Top module: `seq_start_limiter`

## Requirements
- R1: While the reset input is low, and for the two clock edges after it rises (the reset is released synchronously), `start_o` is all zero, whatever the other inputs are.
- R2: A sequence with no condition, spacing or occupancy limit and a full probability code starts on every cycle, even with many instances already live.
- R3: A sequence with a condition limit cannot start in a cycle where its `cond_i` bit is 0. With every other limit passing and a full probability code, it starts in every cycle where that bit is 1.
- R4: After any member of a spacing group with gap G starts in cycle t, no member of that group starts before cycle t+G.
- R5: Within one cycle, at most one member of any shared group starts. A requesting sequence is suppressed whenever a lower-indexed requester shares a group with it. With gap 1, members may start in consecutive cycles.
- R6: An instance counts as live from its start cycle through the cycle of its completion pulse. A member of an occupancy group with limit L cannot start while the group's live total is L or more. It may start in the cycle after a completion brings the total below L.
- R7: Condition, spacing and occupancy limits combine: a sequence needing all three starts only when all three pass.
- R8: The probability code is PROB_W+1 bits wide. Code 0 never starts the sequence. A code of 2^PROB_W or more starts it in every eligible cycle. A code p in between starts it in about p/2^PROB_W of eligible cycles.
- R9: Pulsing `seed_ld_i` loads `seed_i` into the generator at the clock edge. The same seed then gives the same start pattern from the next cycle on. A zero seed is replaced by a fixed nonzero value, so the draws never stall.
- R10: A completion pulse for a sequence with no live instance from an earlier cycle is ignored. Live counts never wrap below zero and saturate at their top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_i | input | N_SEQ | Per-sequence start condition; bit i is used only if sequence i has a condition limit |
| done_i | input | N_SEQ | Per-sequence completion pulse, one instance retired per pulse |
| prob_i | input | N_SEQ*(PROB_W+1) | Per-sequence probability codes, sequence i in bits [i*(PROB_W+1) +: PROB_W+1] |
| seed_i | input | 32 | Generator seed |
| seed_ld_i | input | 1 | Loads `seed_i` at the next rising edge |
| start_o | output | N_SEQ | Per-sequence start pulse |

## Verification
Every cycle, the assertions check the following:
- no start while a sequence's condition is low or its code is zero;
- no back-to-back starts in a spacing group whose gap exceeds one;
- at most one start per group per cycle;
- no start while an occupancy group is full;
- live counts neither wrap nor overflow;
- the generator never reaches zero.

The bench scenarios cover what a per-cycle property cannot express:
- the exact cycles at which a capped and spaced sequence resumes after completions;
- that unmatched completions leave the cap usable;
- the start rate produced by intermediate codes;
- that reloading a seed repeats the start pattern while a different seed changes it.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int          LFSR_W    = 32;
  // right-shift Galois feedback mask for a maximal-length 32-bit register
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
  // substitute state when a zero seed is requested
  localparam logic [31:0] SEED_ALT  = 32'h0000_0001;
endpackage

// File: rtl/rsl_lfsr.sv
module rsl_lfsr
  import rsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] st_q, st_d;

  always_comb begin
    if (ld) begin
      st_d = (seed == '0) ? SEED_ALT : seed;
    end else begin
      st_d = {1'b0, st_q[LFSR_W-1:1]} ^ (st_q[0] ? LFSR_TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED_ALT;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R9: the generator can never lock up in the all-zero state
  assert_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/rsl_gap_timer.sv
module rsl_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap,
  input  logic             fire,
  output logic             open
);
  logic [GAP_W-1:0] tmr_q, tmr_d;
  logic             tick;

  always_comb begin
    tick  = fire | (tmr_q != '0);
    tmr_d = tmr_q;
    if (fire) begin
      tmr_d = (gap > GAP_W'(1)) ? gap - GAP_W'(1) : '0;
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr_q <= '0;
    else if (tick) tmr_q <= tmr_d;
  end

  assign open = (tmr_q == '0);
endmodule

// File: rtl/rsl_live_cnt.sv
module rsl_live_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok, en;

  always_comb begin
    dec_ok = dec & (cnt_q != '0);
    en     = (inc ^ dec_ok) & ~(inc & (cnt_q == TOP));
    cnt_d  = inc ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R10: an unmatched completion leaves an empty count at zero
  assert_noneg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc) |=> cnt_q == '0);
  // R10: a full count holds instead of wrapping
  assert_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && inc && !dec) |=> cnt_q == TOP);
endmodule

// File: rtl/seq_start_limiter.sv
module seq_start_limiter
  import rsl_pkg::*;
#(
  parameter int N_SEQ  = 4,
  parameter int N_DGRP = 2,
  parameter int N_MGRP = 2,
  parameter int PROB_W = 8,
  parameter int CNT_W  = 3,
  parameter int GAP_W  = 4,
  parameter logic [N_SEQ-1:0]        COND_MASK = 4'b1010,
  parameter logic [N_DGRP*N_SEQ-1:0] DGRP_MEMB = 8'b1000_0110,
  parameter logic [N_DGRP*GAP_W-1:0] DGRP_GAP  = {4'd2, 4'd1},
  parameter logic [N_MGRP*N_SEQ-1:0] MGRP_MEMB = 8'b1000_0100,
  parameter logic [N_MGRP*CNT_W-1:0] MGRP_LIM  = {3'd4, 3'd1}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SEQ-1:0]          cond_i,
  input  logic [N_SEQ-1:0]          done_i,
  input  logic [N_SEQ*(PROB_W+1)-1:0] prob_i,
  input  logic [LFSR_W-1:0]         seed_i,
  input  logic                      seed_ld_i,
  output logic [N_SEQ-1:0]          start_o
);
  localparam int PW1   = PROB_W + 1;
  localparam int SUM_W = CNT_W + $clog2(N_SEQ + 1);

  // two sequences are coupled when any spacing or occupancy group holds both
  function automatic logic coupled(int a, int b);
    logic r;
    r = 1'b0;
    for (int g = 0; g < N_DGRP; g++)
      if (DGRP_MEMB[g*N_SEQ+a] && DGRP_MEMB[g*N_SEQ+b]) r = 1'b1;
    for (int g = 0; g < N_MGRP; g++)
      if (MGRP_MEMB[g*N_SEQ+a] && MGRP_MEMB[g*N_SEQ+b]) r = 1'b1;
    return r;
  endfunction

  // ---------------- reset release synchronizer ----------------
  logic rst_s1, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      run    <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      run    <= rst_s1;
    end
  end

  // R1: nothing starts before the synchronized reset has released
  assert_quiet_R1: assert property (@(posedge clk)
    !run |-> start_o == '0);

  // ---------------- random source ----------------
  logic [LFSR_W-1:0] lfsr_st;

  rsl_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (run),
    .ld    (seed_ld_i),
    .seed  (seed_i),
    .state (lfsr_st)
  );

  // ---------------- spacing groups ----------------
  logic [N_DGRP-1:0] dg_open;

  for (genvar g = 0; g < N_DGRP; g++) begin : g_dgrp
    localparam logic [N_SEQ-1:0] DM = DGRP_MEMB[g*N_SEQ +: N_SEQ];
    localparam logic [GAP_W-1:0] DG = DGRP_GAP[g*GAP_W +: GAP_W];
    logic fire;

    assign fire = |(start_o & DM);

    rsl_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk   (clk),
      .rst_n (run),
      .gap   (DG),
      .fire  (fire),
      .open  (dg_open[g])
    );

    // R5: one start per group per cycle
    assert_onegrp_R5: assert property (@(posedge clk) disable iff (!run)
      $onehot0(start_o & DM));
    if (DG > GAP_W'(1)) begin : g_spaced
      // R4: a gap above one forbids starts in the following cycle
      assert_gap_R4: assert property (@(posedge clk) disable iff (!run)
        fire |=> !(|(start_o & DM)));
    end
  end

  // ---------------- live instance counters ----------------
  logic [CNT_W-1:0] live [N_SEQ];

  for (genvar i = 0; i < N_SEQ; i++) begin : g_live
    rsl_live_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (run),
      .inc   (start_o[i]),
      .dec   (done_i[i]),
      .cnt   (live[i])
    );
  end

  // ---------------- occupancy groups ----------------
  logic [N_MGRP-1:0] mg_ok;

  for (genvar g = 0; g < N_MGRP; g++) begin : g_mgrp
    localparam logic [N_SEQ-1:0] MM = MGRP_MEMB[g*N_SEQ +: N_SEQ];
    localparam logic [CNT_W-1:0] ML = MGRP_LIM[g*CNT_W +: CNT_W];
    logic [SUM_W-1:0] total;

    always_comb begin
      total = '0;
      for (int i = 0; i < N_SEQ; i++)
        if (MM[i]) total = total + SUM_W'(live[i]);
    end

    assign mg_ok[g] = (total < SUM_W'(ML));

    // R6: a full group issues no start
    assert_cap_R6: assert property (@(posedge clk) disable iff (!run)
      (total >= SUM_W'(ML)) |-> !(|(start_o & MM)));
  end

  // ---------------- per-sequence eligibility and grant ----------------
  logic [N_SEQ-1:0] req;

  for (genvar i = 0; i < N_SEQ; i++) begin : g_seq
    localparam int OFS = (i * PROB_W) % LFSR_W;
    logic [PROB_W-1:0] rnd;
    logic [PW1-1:0]    prob;
    logic              cond_ok, dly_ok, cap_ok, win, blk;

    always_comb begin
      for (int b = 0; b < PROB_W; b++) rnd[b] = lfsr_st[(OFS + b) % LFSR_W];
      prob    = prob_i[i*PW1 +: PW1];
      win     = ({1'b0, rnd} < prob);
      cond_ok = ~COND_MASK[i] | cond_i[i];
      dly_ok  = 1'b1;
      for (int g = 0; g < N_DGRP; g++)
        if (DGRP_MEMB[g*N_SEQ+i] && !dg_open[g]) dly_ok = 1'b0;
      cap_ok  = 1'b1;
      for (int g = 0; g < N_MGRP; g++)
        if (MGRP_MEMB[g*N_SEQ+i] && !mg_ok[g]) cap_ok = 1'b0;
    end

    assign req[i] = run & cond_ok & dly_ok & cap_ok & win;

    always_comb begin
      blk = 1'b0;
      for (int j = 0; j < i; j++)
        if (coupled(i, j) && req[j]) blk = 1'b1;
    end

    assign start_o[i] = req[i] & ~blk;

    // R8: a zero code keeps the sequence idle
    assert_prob_R8: assert property (@(posedge clk) disable iff (!run)
      (prob == '0) |-> !start_o[i]);
    if (COND_MASK[i]) begin : g_cond
      // R3: a low condition blocks the start
      assert_cond_R3: assert property (@(posedge clk) disable iff (!run)
        !cond_i[i] |-> !start_o[i]);
    end
  end
endmodule

// File: tb/sim_seq_start_limiter.sv
`timescale 1ns/1ps
module sim_seq_start_limiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cond, done;
  logic [8:0]  pr [4];
  logic [31:0] seed;
  logic        seed_ld;
  logic [3:0]  start;
  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seq_start_limiter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond),
    .done_i    (done),
    .prob_i    ({pr[3], pr[2], pr[1], pr[0]}),
    .seed_i    (seed),
    .seed_ld_i (seed_ld),
    .start_o   (start)
  );

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic chk_rng(input string rq, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", rq, act, lo, hi);
    end
  endtask

  // record 64 draws of sequence 0 right after loading a seed
  task automatic seeded_run(input logic [31:0] s, output logic [63:0] v);
    @(negedge clk); seed = s; seed_ld = 1'b1;
    @(negedge clk); seed_ld = 1'b0;
    for (int t = 0; t < 64; t++) begin
      if (t > 0) @(negedge clk);
      #1 v[t] = start[0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] va, vb, vc;
    int n;
    rst_n = 1'b0; cond = 4'hF; done = '0; seed = '0; seed_ld = 1'b0;
    for (int i = 0; i < 4; i++) pr[i] = 9'd256;
    // R1: all limits open and full codes, yet quiet under reset
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); #1 chk("R1 in reset", start, 0);
    end
    @(negedge clk); rst_n = 1'b1; #1 chk("R1 release edge", start, 0);
    @(negedge clk); #1 chk("R1 sync stage", start, 0);
    @(negedge clk); for (int i = 0; i < 4; i++) pr[i] = 9'd0;
    repeat (3) @(negedge clk);

    // R8: zero codes never start
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); #1 chk("R8 zero code", start, 0);
    end

    // R2: unlimited sequence, pipelined far beyond the counter top
    @(negedge clk); pr[0] = 9'd256;
    for (int t = 0; t < 20; t++) begin
      #1 chk("R2 every cycle", start, 4'b0001);
      @(negedge clk);
    end
    pr[0] = 9'd0;

    // R3: condition-gated sequence 1 follows its condition bit
    pr[1] = 9'd256;
    for (int t = 0; t < 12; t++) begin
      cond[1] = (t % 3) != 0;
      #1 chk("R3 condition", start, {2'b00, cond[1], 1'b0});
      @(negedge clk);
    end

    // R5: sequences 1 and 2 share a gap-1 group, lower index wins
    cond[1] = 1'b1; pr[2] = 9'd256;
    for (int t = 0; t < 10; t++) begin
      #1 chk("R5 lowest index wins", start, 4'b0010);
      @(negedge clk);
    end

    // R6: sequence 2 has an occupancy limit of one
    cond[1] = 1'b0;
    #1 chk("R6 first start", start, 4'b0100);
    for (int t = 1; t < 6; t++) begin
      @(negedge clk); #1 chk("R6 capped", start, 0);
    end
    @(negedge clk); done[2] = 1'b1; #1 chk("R6 live through completion cycle", start, 0);
    @(negedge clk); done[2] = 1'b0; #1 chk("R6 restart after completion", start, 4'b0100);
    @(negedge clk); pr[2] = 9'd0; pr[1] = 9'd0; done[2] = 1'b1;
    #1 chk("R6 idle", start, 0);
    @(negedge clk); done[2] = 1'b0;

    // R4/R7: sequence 3 with condition, gap 2 and limit 4
    cond[3] = 1'b1; pr[3] = 9'd256;
    for (int t = 0; t < 12; t++) begin
      #1 chk("R4 gap and R6 limit", start, (t % 2 == 0 && t < 8) ? 8 : 0);
      @(negedge clk);
    end
    cond[3] = 1'b0; done[3] = 1'b1;
    #1 chk("R7 condition low", start, 0);
    @(negedge clk); #1 chk("R7 condition low", start, 0);
    @(negedge clk); done[3] = 1'b0; #1 chk("R7 gap and cap open, condition low", start, 0);
    @(negedge clk); cond[3] = 1'b1; #1 chk("R7 all limits pass", start, 8);
    @(negedge clk); #1 chk("R4 spacing", start, 0);
    @(negedge clk); #1 chk("R6 fourth live", start, 8);
    @(negedge clk); #1 chk("R6 cap reached", start, 0);
    @(negedge clk); #1 chk("R6 cap reached", start, 0);

    // R10: four real plus three unmatched completions, cap must stay usable
    @(negedge clk); pr[3] = 9'd0;
    for (int t = 0; t < 7; t++) begin
      done[3] = 1'b1; #1 chk("R10 retire", start, 0);
      @(negedge clk);
    end
    done[3] = 1'b0; pr[3] = 9'd256;
    for (int t = 0; t < 10; t++) begin
      #1 chk("R10 no underflow", start, (t % 2 == 0 && t < 8) ? 8 : 0);
      @(negedge clk);
    end
    pr[3] = 9'd0;
    for (int t = 0; t < 4; t++) begin
      done[3] = 1'b1; @(negedge clk);
    end
    done[3] = 1'b0;

    // R8: intermediate codes give proportional start rates
    pr[0] = 9'd128; n = 0;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk); #1 n += start[0];
    end
    chk_rng("R8 half rate", n, 1600, 2400);
    pr[0] = 9'd64; n = 0;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk); #1 n += start[0];
    end
    chk_rng("R8 quarter rate", n, 600, 1400);

    // R9: reproducible from the seed
    pr[0] = 9'd128;
    seeded_run(32'h1234_5678, va);
    seeded_run(32'h1234_5678, vb);
    seeded_run(32'h8765_4321, vc);
    chk("R9 same seed repeats", int'(va == vb), 1);
    chk("R9 other seed differs", int'(va != vc), 1);
    seeded_run(32'h0, va);
    n = $countones(va);
    chk("R9 zero seed still draws", int'(n > 0 && n < 64), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule